// File: doc/BRIEF.md
# Conversion and Calibration Timing Sequencer

This block decides, by counting master-clock cycles, when a converter operation finishes. A start pulse launches one of four operations: a one-shot conversion, a free-running conversion stream, an offset calibration step or a gain calibration step. The block takes a 4-bit rate code and a filter-speed select bit with the start pulse and looks up the duration from them. It raises a one-cycle `done` strobe each time a result would be ready.

In streaming mode the first result takes longer than the ones after it, and the stream keeps running until another start replaces it. A stream that follows a one-shot conversion or a calibration has its leading results marked as unsettled on the `valid` output. The number of such results is a parameter, with a separate count for the fastest rate. Both calibration durations are derived from the one-shot duration by subtracting a fixed trim that depends on the filter-speed select.

Top module: `convtime_seq`

## Requirements
- R1: With `frs`=0, a one-shot conversion (`op`=00) asserts `done` this many cycles after the accepting edge, per rate code: 1000→7592, 1001→17848, 1010→28088, 1011→48568, 1100→89528, 0000→171448, 0001→335288, 0010→662968, 0011→1318328, 0100→2629048.
- R2: With `frs`=1, the one-shot durations are: 1000→9110, 1001→21418, 1010→33706, 1011→58282, 1100→107434, 0000→205738, 0001→402346, 0010→795562, 0011→1581994, 0100→3154858.
- R3: In streaming mode (`op`=01), the first result takes longer than later ones: 2472 cycles for code 1000 and 89528 for code 0000 with `frs`=0, and 15274 for code 1001 with `frs`=1. The other codes follow the same lookup.
- R4: Later streaming results repeat with a fixed period. With `frs`=0 this is 1280·2^k for codes 1000+k and 40960·2^k for codes 0000+k (k=0..4). With `frs`=1 it is 1536·2^k and 49152·2^k.
- R5: Offset calibration (`op`=10) lasts the one-shot duration minus 608 cycles (`frs`=0) or minus 729 cycles (`frs`=1).
- R6: Gain calibration (`op`=11) lasts the one-shot duration minus 128 cycles (`frs`=0) or minus 153 cycles (`frs`=1).
- R7: `valid` is high only together with `done`. It is always high for one-shot and calibration results. When a stream follows a one-shot or calibration result, the first 3 of its results have `valid` low, or the first 5 when the code is 1000. A stream started from another stream has no such results.
- R8: Rate codes 0101–0111 and 1101–1111 use the timing of code 0000. `rate_err` is high from the accepting edge of such a start until the next accepted start.
- R9: A start is accepted when the block is idle, or in streaming mode once the stream has produced at least one result. Otherwise the start is ignored. `busy` falls at the edge that issues the done of a one-shot or calibration operation.
- R10: After reset, `done`, `valid`, `busy` and `rate_err` are all 0.
- R11: `done` is a single-cycle pulse, and a stream keeps issuing results until it is replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled on a rising edge |
| op | input | 2 | Operation: 00 one-shot, 01 stream, 10 offset cal, 11 gain cal |
| rate_code | input | 4 | Output-rate selection code |
| frs | input | 1 | Filter-speed select, picks the longer timing set when 1 |
| done | output | 1 | One-cycle strobe per finished result |
| valid | output | 1 | Result with this strobe is settled |
| busy | output | 1 | An operation is in progress |
| rate_err | output | 1 | Last accepted rate code was unlisted |

## Verification
The bench measures the distance from the accepting edge to each strobe exactly. An off-by-one in the counter reload therefore shows up as a miscount of one cycle, and a wrong calibration trim gives a duration off by that trim. It checks the unsettled-result window at both the fast and the normal rate. A design that counted the skip after decrementing, or ignored the fastest-rate exception, would flag the wrong result as valid. It pulses start in the middle of a one-shot run. A design that accepted that pulse would restart the count and finish late. Finally, an unlisted code must not fall back to a fast timing, so no strobe may appear within 10000 cycles.

// File: rtl/convtime_pkg.sv
package convtime_pkg;

  localparam int LEN_W  = 22;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    OP_SINGLE  = 2'd0,
    OP_CONT    = 2'd1,
    OP_OFFCAL  = 2'd2,
    OP_GAINCAL = 2'd3
  } op_e;

  function automatic logic code_listed(input logic [CODE_W-1:0] c);
    return (c <= 4'd4) || ((c >= 4'd8) && (c <= 4'd12));
  endfunction

  // one-shot conversion duration in cycles
  function automatic logic [LEN_W-1:0] oneshot_len(input logic f, input logic [CODE_W-1:0] c);
    logic [LEN_W-1:0] r;
    case ({f, c})
      5'h00: r = LEN_W'(171448);
      5'h01: r = LEN_W'(335288);
      5'h02: r = LEN_W'(662968);
      5'h03: r = LEN_W'(1318328);
      5'h04: r = LEN_W'(2629048);
      5'h08: r = LEN_W'(7592);
      5'h09: r = LEN_W'(17848);
      5'h0A: r = LEN_W'(28088);
      5'h0B: r = LEN_W'(48568);
      5'h0C: r = LEN_W'(89528);
      5'h10: r = LEN_W'(205738);
      5'h11: r = LEN_W'(402346);
      5'h12: r = LEN_W'(795562);
      5'h13: r = LEN_W'(1581994);
      5'h14: r = LEN_W'(3154858);
      5'h18: r = LEN_W'(9110);
      5'h19: r = LEN_W'(21418);
      5'h1A: r = LEN_W'(33706);
      5'h1B: r = LEN_W'(58282);
      5'h1C: r = LEN_W'(107434);
      default: r = f ? LEN_W'(205738) : LEN_W'(171448);
    endcase
    return r;
  endfunction

  // first result of a stream, includes start-up overhead
  function automatic logic [LEN_W-1:0] stream_first_len(input logic f, input logic [CODE_W-1:0] c);
    logic [LEN_W-1:0] r;
    case ({f, c})
      5'h00: r = LEN_W'(89528);
      5'h01: r = LEN_W'(171448);
      5'h02: r = LEN_W'(335288);
      5'h03: r = LEN_W'(662968);
      5'h04: r = LEN_W'(1318328);
      5'h08: r = LEN_W'(2472);
      5'h09: r = LEN_W'(12728);
      5'h0A: r = LEN_W'(17848);
      5'h0B: r = LEN_W'(28088);
      5'h0C: r = LEN_W'(48568);
      5'h10: r = LEN_W'(107434);
      5'h11: r = LEN_W'(205738);
      5'h12: r = LEN_W'(402346);
      5'h13: r = LEN_W'(795562);
      5'h14: r = LEN_W'(1581994);
      5'h18: r = LEN_W'(2966);
      5'h19: r = LEN_W'(15274);
      5'h1A: r = LEN_W'(21418);
      5'h1B: r = LEN_W'(33706);
      5'h1C: r = LEN_W'(58282);
      default: r = f ? LEN_W'(107434) : LEN_W'(89528);
    endcase
    return r;
  endfunction

  // steady stream period: a base value doubled per code step
  function automatic logic [LEN_W-1:0] stream_period(input logic f, input logic [CODE_W-1:0] c);
    logic [LEN_W-1:0] base;
    if (c[3]) base = f ? LEN_W'(1536) : LEN_W'(1280);
    else      base = f ? LEN_W'(49152) : LEN_W'(40960);
    return base << c[2:0];
  endfunction

endpackage

// File: rtl/convtime_lut.sv
module convtime_lut
  import convtime_pkg::*;
#(
  parameter int OFF_TRIM_SLOW  = 608,
  parameter int OFF_TRIM_FAST  = 729,
  parameter int GAIN_TRIM_SLOW = 128,
  parameter int GAIN_TRIM_FAST = 153
) (
  input  logic              frs,
  input  logic [CODE_W-1:0] code,
  input  op_e               op,
  input  logic              first,
  output logic [LEN_W-1:0]  len,
  output logic              bad
);

  logic [CODE_W-1:0] eff_code;
  logic [LEN_W-1:0]  base_len;

  always_comb begin
    bad      = !code_listed(code);
    eff_code = bad ? '0 : code;
    base_len = oneshot_len(frs, eff_code);
    case (op)
      OP_CONT:    len = first ? stream_first_len(frs, eff_code) : stream_period(frs, eff_code);
      OP_OFFCAL:  len = base_len - (frs ? LEN_W'(OFF_TRIM_FAST) : LEN_W'(OFF_TRIM_SLOW));
      OP_GAINCAL: len = base_len - (frs ? LEN_W'(GAIN_TRIM_FAST) : LEN_W'(GAIN_TRIM_SLOW));
      default:    len = base_len;
    endcase
  end

  // every looked-up duration must allow a countdown of at least one cycle (R1)
  always_comb begin
    assert_len_nonzero_R1: assert (len != '0);
  end

endmodule

// File: rtl/convtime_counter.sv
module convtime_counter #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == '0);

  // the count is frozen when neither loaded nor running (R11)
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!load && !run) |=> $stable(cnt));

endmodule

// File: rtl/convtime_flush.sv
module convtime_flush #(
  parameter int SKIP_SLOW = 3,
  parameter int SKIP_FAST = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic stream_start,
  input  logic fast,
  input  logic result,
  output logic settled
);

  localparam int SKIP_MAX = (SKIP_SLOW > SKIP_FAST) ? SKIP_SLOW : SKIP_FAST;
  localparam int SKIP_W   = $clog2(SKIP_MAX + 1);

  logic              pending;
  logic [SKIP_W-1:0] skip;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      skip    <= '0;
    end else if (stream_start) begin
      pending <= 1'b0;
      skip    <= pending ? (fast ? SKIP_W'(SKIP_FAST) : SKIP_W'(SKIP_SLOW)) : '0;
    end else begin
      if (arm) pending <= 1'b1;
      if (result && skip != '0) skip <= skip - 1'b1;
    end
  end

  assign settled = (skip == '0);

  // the unsettled window never exceeds the larger configured length (R7)
  assert_skip_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    skip <= SKIP_W'(SKIP_MAX));

endmodule

// File: rtl/convtime_seq.sv
module convtime_seq
  import convtime_pkg::*;
#(
  parameter int SKIP_SLOW = 3,
  parameter int SKIP_FAST = 5,
  parameter logic [3:0] FAST_CODE = 4'd8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] op,
  input  logic [3:0] rate_code,
  input  logic       frs,
  output logic       done,
  output logic       valid,
  output logic       busy,
  output logic       rate_err
);

  op_e               op_q;
  logic [CODE_W-1:0] code_q;
  logic              frs_q;
  logic              seen_done;

  logic              accept;
  logic              expire;
  logic              settled;
  logic              lut_bad;
  logic [LEN_W-1:0]  lut_len;
  logic              reload;
  op_e               op_in;
  op_e               op_sel;

  assign op_in  = op_e'(op);
  assign accept = start && (!busy || (op_q == OP_CONT && seen_done));
  assign op_sel = accept ? op_in : op_q;
  assign reload = accept || (expire && op_q == OP_CONT);

  convtime_lut u_lut (
    .frs   (accept ? frs : frs_q),
    .code  (accept ? rate_code : code_q),
    .op    (op_sel),
    .first (accept),
    .len   (lut_len),
    .bad   (lut_bad)
  );

  convtime_counter #(.W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (reload),
    .load_val (lut_len - 1'b1),
    .run      (busy),
    .expire   (expire)
  );

  convtime_flush #(.SKIP_SLOW(SKIP_SLOW), .SKIP_FAST(SKIP_FAST)) u_flush (
    .clk          (clk),
    .rst          (rst),
    .arm          (expire && op_q != OP_CONT),
    .stream_start (accept && op_in == OP_CONT),
    .fast         (rate_code == FAST_CODE),
    .result       (expire && op_q == OP_CONT),
    .settled      (settled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      seen_done <= 1'b0;
      op_q      <= OP_SINGLE;
      code_q    <= '0;
      frs_q     <= 1'b0;
      done      <= 1'b0;
      valid     <= 1'b0;
      rate_err  <= 1'b0;
    end else begin
      done  <= expire;
      valid <= expire && (op_q != OP_CONT || settled);
      if (accept) begin
        busy      <= 1'b1;
        seen_done <= 1'b0;
        op_q      <= op_in;
        code_q    <= rate_code;
        frs_q     <= frs;
        rate_err  <= lut_bad;
      end else if (expire) begin
        if (op_q == OP_CONT) seen_done <= 1'b1;
        else                 busy      <= 1'b0;
      end
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_needs_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  assert_oneshot_ends_R9: assert property (@(posedge clk) disable iff (rst)
    (done && op_q != OP_CONT) |-> !busy);

  assert_valid_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    valid |-> done);

  assert_err_held_R8: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(rate_err));

endmodule

// File: tb/convtime_seq_test.sv
module convtime_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [3:0] rate_code = 4'd8;
  logic       frs = 1'b0;
  logic       done, valid, busy, rate_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  convtime_seq uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .rate_code(rate_code),
    .frs(frs), .done(done), .valid(valid), .busy(busy), .rate_err(rate_err)
  );

  // {op, code, frs, expected cycles}
  localparam int NV = 6;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 4'd8, 1'b0, 22'd7592},   // R1 one-shot
    {2'd0, 4'd8, 1'b1, 22'd9110},   // R2 one-shot
    {2'd2, 4'd8, 1'b0, 22'd6984},   // R5 offset cal
    {2'd3, 4'd8, 1'b1, 22'd8957},   // R6 gain cal
    {2'd2, 4'd9, 1'b1, 22'd20689},  // R5 offset cal
    {2'd3, 4'd9, 1'b0, 22'd17720}   // R6 gain cal
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // drive a start; returns at the negedge just after the accepting edge
  task automatic launch(input logic [1:0] o, input logic [3:0] c, input logic f);
    @(negedge clk);
    start = 1'b1; op = o; rate_code = c; frs = f;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int n0, input int limit, output int n);
    n = n0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < limit);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 done", done, 0);
    check("R10 valid", valid, 0);
    check("R10 busy", busy, 0);
    check("R10 rate_err", rate_err, 0);

    // R1 R2 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][28:27], VEC[i][26:23], VEC[i][22]);
      check("R8 listed code no error", rate_err, 0);
      wait_done(0, 200000, n);
      check($sformatf("R1/R2/R5/R6 length vec%0d", i), n, int'(VEC[i][21:0]));
      check("R7 oneshot/cal valid", valid, 1);
      check("R9 busy falls", busy, 0);
    end

    // R3 R4 R7 stream after calibration, fastest code: 5 unsettled
    launch(2'd1, 4'd8, 1'b0);
    wait_done(0, 200000, n);
    check("R3 first stream result", n, 2472);
    check("R7 fast skip result 1", valid, 0);
    for (int k = 2; k <= 6; k++) begin
      wait_done(0, 200000, n);
      check("R4 stream period", n, 1280);
      check($sformatf("R7 fast skip result %0d", k), valid, (k == 6) ? 1 : 0);
    end
    @(negedge clk);
    check("R11 done single cycle", done, 0);

    // R9 restart from stream, R3 FRS=1, no skip window
    launch(2'd1, 4'd9, 1'b1);
    wait_done(0, 200000, n);
    check("R3 first stream result frs1", n, 15274);
    check("R7 stream-from-stream valid", valid, 1);
    wait_done(0, 200000, n);
    check("R4 stream period frs1", n, 3072);
    check("R11 stream continues", busy, 1);

    // R9 start ignored during one-shot
    launch(2'd0, 4'd8, 1'b0);
    n = 0;
    repeat (50) begin @(negedge clk); n++; end
    start = 1'b1; op = 2'd2; rate_code = 4'd9;
    @(negedge clk); n++;
    start = 1'b0;
    wait_done(n, 200000, n);
    check("R9 ignored start keeps length", n, 7592);
    check("R9 busy falls after oneshot", busy, 0);

    // R7 normal code after one-shot: 3 unsettled
    launch(2'd1, 4'd9, 1'b0);
    wait_done(0, 200000, n);
    check("R3 first stream code 1001", n, 12728);
    check("R7 normal skip result 1", valid, 0);
    for (int k = 2; k <= 4; k++) begin
      wait_done(0, 200000, n);
      check("R4 stream period 1001", n, 2560);
      check($sformatf("R7 normal skip result %0d", k), valid, (k == 4) ? 1 : 0);
    end

    // R8 unlisted code: error flag, slow fallback timing
    launch(2'd0, 4'd5, 1'b0);
    check("R8 rate_err set", rate_err, 1);
    check("R8 busy", busy, 1);
    wait_done(0, 10000, n);
    check("R8 no early done", n, 10000);
    check("R8 rate_err held", rate_err, 1);

    // R10 reset mid-operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 busy after reset", busy, 0);
    check("R10 rate_err after reset", rate_err, 0);
    check("R10 done after reset", done, 0);
    summary();
  end

endmodule